// File: doc/BRIEF.md
# Stack Pointer Window Monitor

This block watches the stack pointer of one processor core on every cycle in which the core marks its outputs valid. It compares the pointer, as an unsigned number, against a programmable floor and ceiling. A pointer below the floor is an underflow event. A pointer above the ceiling is an overflow event. Each kind of event has its own detection enable, sticky status bit, interrupt enable and write-one-to-clear bit. When the first event arrives with both status bits clear, the program counter that came with it is captured for software to read.

A system instantiates one copy per core. Software programs the two bounds and the control word through a simple write port. It reads the bounds, control, status, masked status and captured program counter through a combinational read port. The level interrupt stays asserted while any enabled status bit is set. A separate output shows whether either status bit is set, whatever the interrupt enables say.

A parameter chooses whether the comparison is registered once before it reaches the status bits. The registered form adds one cycle of latency and shortens the path from the core.

Top module: `sp_window_guard`

## Requirements
- R1: Address 0 holds the floor and address 1 holds the ceiling. Each is DATA_W bits wide, resets to 0, is written whole by a write to its address and reads back the last value written.
- R2: Address 2 is the control word. Bit 0 enables underflow detection, bit 1 enables overflow detection, bit 2 enables the underflow interrupt and bit 3 enables the overflow interrupt. The word resets to 0, and reads return these four bits with zeros above them.
- R3: An underflow is a valid cycle with bit 0 of control set and pointer < floor, compared unsigned. It sets status bit 0 at the first clock edge after it when PIPE_CMP=0 and at the second edge when PIPE_CMP=1. A pointer equal to the floor is not an underflow.
- R4: An overflow is a valid cycle with bit 1 of control set and pointer > ceiling, compared unsigned. It sets status bit 1 with the same latency as R3. A pointer equal to the ceiling is not an overflow.
- R5: Status bits, read at address 3, are sticky. A write to address 3 clears each status bit whose data bit is 1 (bit 0 underflow, bit 1 overflow). An event that reaches a status bit in the same cycle as its clear wins, and the bit stays set.
- R6: hit_any is high exactly while at least one status bit is set.
- R7: irq is the OR of (status bit 0 AND control bit 2) and (status bit 1 AND control bit 3). Address 5 reads these two masked bits at positions 0 and 1.
- R8: Address 4 reads the captured program counter, which resets to 0. It takes the program counter of an event that reaches the status bits while both status bits are 0. Later events do not overwrite it until software has cleared both status bits.
- R9: Cycles with the valid strobe low, and out-of-window pointers whose detection enable is 0, leave the status bits and the captured program counter unchanged. Reads at addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| sp_valid | input | 1 | Core pointer and program counter are valid this cycle |
| sp_value | input | DATA_W | Stack pointer from the core |
| pc_value | input | DATA_W | Program counter from the core |
| hit_any | output | 1 | At least one status bit is set |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with DATA_W=16 and PIPE_CMP=1. The narrow width lets directed stimulus reach the all-ones pointer and bounds at the top of the range. The pipelined variant exercises the extra cycle between an event and its status bit, and the case of an event landing in the same cycle as a clear. A behavioural model in the bench delays events through a one-entry queue and predicts every read address, hit_any and irq on every clock. Directed runs cover the bounds equal to the pointer, disabled detection, low strobe and partial interrupt enables, and a random run follows them.

// File: rtl/swg_pkg.sv
package swg_pkg;

   localparam int unsigned REG_FLOOR   = 0;
   localparam int unsigned REG_CEIL    = 1;
   localparam int unsigned REG_CTRL    = 2;
   localparam int unsigned REG_STATUS  = 3;
   localparam int unsigned REG_CAPPC   = 4;
   localparam int unsigned REG_MASKED  = 5;

   localparam int unsigned CTRL_W      = 4;
   localparam int unsigned EVT_W       = 2;

   // bit 0 first: under_det, over_det, under_ie, over_ie
   typedef struct packed {
      logic over_ie;
      logic under_ie;
      logic over_det;
      logic under_det;
   } swg_ctrl_t;

endpackage

// File: rtl/swg_regs.sv
module swg_regs
   import swg_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] floor_q,
   output logic [DATA_W-1:0] ceil_q,
   output swg_ctrl_t         ctrl_q,
   output logic [EVT_W-1:0]  clr_pulse
);

   localparam logic [ADDR_W-1:0] A_FLOOR  = ADDR_W'(REG_FLOOR);
   localparam logic [ADDR_W-1:0] A_CEIL   = ADDR_W'(REG_CEIL);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         floor_q <= '0;
         ceil_q  <= '0;
         ctrl_q  <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_FLOOR) floor_q <= wr_data;
         if (wr_addr == A_CEIL)  ceil_q  <= wr_data;
         if (wr_addr == A_CTRL)  ctrl_q  <= swg_ctrl_t'(wr_data[CTRL_W-1:0]);
      end
   end

   always_comb begin
      clr_pulse = '0;
      if (wr_en && (wr_addr == A_STATUS)) clr_pulse = wr_data[EVT_W-1:0];
   end

endmodule

// File: rtl/swg_cmp.sv
module swg_cmp
   import swg_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter bit          PIPE_CMP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic [DATA_W-1:0] sp,
   input  logic [DATA_W-1:0] pc,
   input  logic [DATA_W-1:0] floor_q,
   input  logic [DATA_W-1:0] ceil_q,
   input  logic              under_det,
   input  logic              over_det,
   output logic [EVT_W-1:0]  evt,
   output logic [DATA_W-1:0] evt_pc
);

   logic [EVT_W-1:0] hit_now;

   always_comb begin
      hit_now[0] = valid && under_det && (sp < floor_q);
      hit_now[1] = valid && over_det  && (sp > ceil_q);
   end

   generate
      if (PIPE_CMP) begin : g_piped
         logic [EVT_W-1:0]  evt_q;
         logic [DATA_W-1:0] pc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               evt_q <= '0;
               pc_q  <= '0;
            end else begin
               evt_q <= hit_now;
               pc_q  <= pc;
            end
         end
         assign evt    = evt_q;
         assign evt_pc = pc_q;

         assert_idle_no_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !valid |=> (evt == '0))
            else $error("registered event after an invalid cycle");
      end else begin : g_direct
         assign evt    = hit_now;
         assign evt_pc = pc;

         assert_one_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (floor_q <= ceil_q) |-> !(evt[0] && evt[1]))
            else $error("both sides hit with an ordered window");
      end
   endgenerate

endmodule

// File: rtl/swg_status.sv
module swg_status
   import swg_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EVT_W-1:0]  evt,
   input  logic [DATA_W-1:0] evt_pc,
   input  logic [EVT_W-1:0]  clr_pulse,
   input  logic [EVT_W-1:0]  ie,
   output logic [EVT_W-1:0]  raw_q,
   output logic [DATA_W-1:0] cap_pc_q,
   output logic              hit_any,
   output logic              irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q    <= '0;
         cap_pc_q <= '0;
      end else begin
         raw_q <= (raw_q & ~clr_pulse) | evt;
         if ((raw_q == '0) && (evt != '0)) cap_pc_q <= evt_pc;
      end
   end

   assign hit_any = |raw_q;
   assign irq     = |(raw_q & ie);

   assert_sticky_under_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q[0] && !clr_pulse[0]) |=> raw_q[0])
      else $error("underflow status dropped without clear");

   assert_sticky_over_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q[1] && !clr_pulse[1]) |=> raw_q[1])
      else $error("overflow status dropped without clear");

   assert_rise_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q[0]) |-> $past(evt[0]))
      else $error("underflow status rose without event");

   assert_rise_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q[1]) |-> $past(evt[1]))
      else $error("overflow status rose without event");

   assert_cap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q != '0) |=> $stable(cap_pc_q))
      else $error("captured pc overwritten while status set");

   assert_irq_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> hit_any)
      else $error("interrupt without any status bit");

endmodule

// File: rtl/sp_window_guard.sv
module sp_window_guard
   import swg_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 3,
   parameter bit          PIPE_CMP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              sp_valid,
   input  logic [DATA_W-1:0] sp_value,
   input  logic [DATA_W-1:0] pc_value,
   output logic              hit_any,
   output logic              irq
);

   generate
      if (DATA_W < CTRL_W) begin : g_bad_width
         $error("DATA_W must hold the control word");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must reach six registers");
      end
   endgenerate

   logic [DATA_W-1:0] floor_q, ceil_q, evt_pc, cap_pc_q;
   swg_ctrl_t         ctrl_q;
   logic [EVT_W-1:0]  clr_pulse, evt, raw_q, ie;

   swg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .floor_q   (floor_q),
      .ceil_q    (ceil_q),
      .ctrl_q    (ctrl_q),
      .clr_pulse (clr_pulse)
   );

   swg_cmp #(.DATA_W(DATA_W), .PIPE_CMP(PIPE_CMP)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (sp_valid),
      .sp        (sp_value),
      .pc        (pc_value),
      .floor_q   (floor_q),
      .ceil_q    (ceil_q),
      .under_det (ctrl_q.under_det),
      .over_det  (ctrl_q.over_det),
      .evt       (evt),
      .evt_pc    (evt_pc)
   );

   assign ie = {ctrl_q.over_ie, ctrl_q.under_ie};

   swg_status #(.DATA_W(DATA_W)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt),
      .evt_pc    (evt_pc),
      .clr_pulse (clr_pulse),
      .ie        (ie),
      .raw_q     (raw_q),
      .cap_pc_q  (cap_pc_q),
      .hit_any   (hit_any),
      .irq       (irq)
   );

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(REG_FLOOR):  rd_data = floor_q;
         ADDR_W'(REG_CEIL):   rd_data = ceil_q;
         ADDR_W'(REG_CTRL):   rd_data = DATA_W'(ctrl_q);
         ADDR_W'(REG_STATUS): rd_data = DATA_W'(raw_q);
         ADDR_W'(REG_CAPPC):  rd_data = cap_pc_q;
         ADDR_W'(REG_MASKED): rd_data = DATA_W'(raw_q & ie);
         default:             rd_data = '0;
      endcase
   end

endmodule

// File: tb/sp_window_guard_bench.sv
module sp_window_guard_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          sp_valid = 1'b0;
   logic [DW-1:0] sp_value = '0;
   logic [DW-1:0] pc_value = '0;
   logic          hit_any, irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sp_window_guard #(.DATA_W(DW), .ADDR_W(AW), .PIPE_CMP(1'b1)) u_sp_window_guard (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .sp_valid(sp_valid), .sp_value(sp_value),
      .pc_value(pc_value), .hit_any(hit_any), .irq(irq)
   );

   // behavioural reference
   int unsigned m_floor, m_ceil, m_ctrl, m_raw, m_cap;
   int unsigned q_evt[$];
   int unsigned q_pc[$];

   initial begin
      q_evt.push_back(0);
      q_pc.push_back(0);
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_floor = 0; m_ceil = 0; m_ctrl = 0; m_raw = 0; m_cap = 0;
         q_evt.delete(); q_pc.delete();
         q_evt.push_back(0); q_pc.push_back(0);
      end else begin
         int unsigned e, p, newe, clr;
         e = q_evt.pop_front();
         p = q_pc.pop_front();
         clr = (wr_en && wr_addr == 3) ? (wr_data & 3) : 0;
         if (m_raw == 0 && e != 0) m_cap = p;
         m_raw = (m_raw & ~clr & 3) | e;
         newe = 0;
         if (sp_valid && (m_ctrl & 1) && sp_value < m_floor) newe |= 1;
         if (sp_valid && (m_ctrl & 2) && sp_value > m_ceil)  newe |= 2;
         q_evt.push_back(newe);
         q_pc.push_back(pc_value);
         if (wr_en) begin
            if (wr_addr == 0) m_floor = wr_data;
            if (wr_addr == 1) m_ceil = wr_data;
            if (wr_addr == 2) m_ctrl = wr_data & 15;
         end
      end
   end

   function automatic int unsigned exp_read(input int unsigned a);
      case (a)
         0: return m_floor;
         1: return m_ceil;
         2: return m_ctrl;
         3: return m_raw;
         4: return m_cap;
         5: return m_raw & (m_ctrl >> 2);
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(input int unsigned a);
      case (a)
         0, 1: return "R1";
         2: return "R2";
         3: return "R3 R4 R5 R9";
         4: return "R8";
         5: return "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input int unsigned act, input int unsigned expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (!done) begin
         int unsigned ra;
         ra = rd_addr;
         chk(tag_of(ra), "rd_data", rd_data, exp_read(ra));
         chk("R6", "hit_any", hit_any, (m_raw != 0) ? 1 : 0);
         chk("R7", "irq", irq, ((m_raw & (m_ctrl >> 2)) != 0) ? 1 : 0);
      end
   end

   task automatic cyc(input bit v, input int unsigned sp, input int unsigned pc);
      @(negedge clk);
      wr_en = 1'b0;
      sp_valid = v; sp_value = DW'(sp); pc_value = DW'(pc);
      rd_addr = AW'((rd_addr + 1) % 6);
   endtask

   task automatic wr(input int unsigned a, input int unsigned d);
      @(negedge clk);
      sp_valid = 1'b0;
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
      rd_addr = AW'((rd_addr + 1) % 6);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(6);                              // R1 R2 reset reads
      wr(0, 16'h1000); wr(1, 16'h8000); wr(2, 15);
      idle(6);
      cyc(1, 16'h1000, 16'h0100);           // R3 equal floor: no event
      cyc(1, 16'h8000, 16'h0101);           // R4 equal ceiling: no event
      cyc(1, 16'h4000, 16'h0102);
      idle(6);
      cyc(1, 16'h0FFF, 16'h0111);           // R3 underflow, R8 capture
      cyc(1, 16'h9000, 16'h0222);           // R4 overflow, no recapture
      cyc(1, 16'h4000, 16'h0333);           // R5 sticky
      idle(6);
      wr(3, 1);                             // R5 clear underflow only
      idle(6);
      wr(3, 2);
      idle(6);
      cyc(1, 16'hFFFF, 16'h0444);           // R4 all-ones pointer
      idle(1);
      wr(3, 2);                             // clear while status set
      cyc(1, 16'hFFFF, 16'h0555);
      wr(3, 2);                             // event arrives with clear: set wins
      idle(6);
      wr(3, 3);
      cyc(0, 16'h0000, 16'h0666);           // R9 invalid strobe
      idle(6);
      wr(2, 12);                            // R9 detection off
      cyc(1, 16'h0000, 16'h0777);
      cyc(1, 16'hFFFF, 16'h0778);
      idle(6);
      wr(2, 3);                             // R7 interrupts masked
      cyc(1, 16'h0001, 16'h0888);
      idle(6);
      wr(2, 7);
      idle(6);
      wr(3, 3);
      wr(1, 16'hFFFF); wr(2, 15);
      cyc(1, 16'hFFFF, 16'h0999);           // R4 no overflow at max ceiling
      idle(6);
      for (int k = 0; k < 3000; k++) begin
         int unsigned r;
         r = $urandom % 20;
         if (r == 0) wr(3, $urandom % 4);
         else if (r == 1) wr(2, $urandom % 16);
         else if (r == 2) wr($urandom % 2, $urandom % 65536);
         else cyc(($urandom % 4) != 0, $urandom % 65536, $urandom % 65536);
      end
      idle(6);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule